// File: doc/BRIEF.md
# Per-Channel Overcurrent Fault Supervisor

This block watches four PWM power-stage channels and decides, per channel, whether an overcurrent condition merely raises a flag or shuts the channel off. Each channel has two comparator inputs, one for a low current threshold and one for a high threshold. It also has a PWM activity input. The block drives an active-low error flag and an output-enable per channel; a deasserted enable means the stage output floats. A low-threshold event is reported only while it lasts. A high-threshold event disables the channel and is held until the controller stops that channel's PWM drive for a configurable number of cycles.

Global inputs act on all channels. An active-low power-down input disables every output and resets every held fault. An over-temperature shutdown flag and an undervoltage flag disable every output while present. A separate over-temperature warning flag drives only an active-low warning output. All asynchronous inputs pass through a two-flop synchronizer. All outputs come from registers.

Top module: `ocp_fault_supervisor`

## Requirements
- R1: Channels are independent. A fault or a clear on one channel leaves the error and enable outputs of the other channels unchanged. The channel count is the parameter NUM_CH (default 4). Bit i of every per-channel vector belongs to channel i.
- R2: A low-threshold flag drives that channel's err_no low 3 clock edges after the input rises. err_no returns high 3 edges after the flag falls. The flag never deasserts out_en_o.
- R3: A high-threshold flag drives that channel's err_no low and its out_en_o low 3 edges after the input rises. Both stay in that state after the flag falls.
- R4: A held fault clears when pwm_act_i of that channel has been low for ACK_CYCLES consecutive cycles. The clear shows at the outputs ACK_CYCLES+3 edges after the input falls, with err_no high and out_en_o high. A low run of ACK_CYCLES-1 cycles does not clear the fault.
- R5: Set has priority over clear. While the high-threshold flag is still present, the fault stays held however long PWM drive has been off.
- R6: While pwr_dn_ni is low, every out_en_o is low and every held fault is reset. After pwr_dn_ni returns high, with no fault present, all enables return high.
- R7: temp_warn_i drives temp_warn_no low, with 3 edges of latency. It has no effect on out_en_o or err_no.
- R8: While temp_shut_i is high, every out_en_o is low. err_no is unaffected, and enables return when the flag falls.
- R9: While uv_i is high, every out_en_o is low. Enables return when the flag falls.
- R10: While rst_ni is low: err_no is all ones, out_en_o is all zeros, and temp_warn_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_ni | input | 1 | Power-down, active low, asynchronous |
| oc_lo_i | input | NUM_CH | Low-threshold overcurrent flags |
| oc_hi_i | input | NUM_CH | High-threshold overcurrent flags |
| pwm_act_i | input | NUM_CH | PWM drive level per channel |
| temp_warn_i | input | 1 | Over-temperature warning level |
| temp_shut_i | input | 1 | Over-temperature shutdown level |
| uv_i | input | 1 | Undervoltage flag |
| err_no | output | NUM_CH | Error flags, active low |
| out_en_o | output | NUM_CH | Stage output enable, low means high impedance |
| temp_warn_no | output | 1 | Temperature warning, active low |

## Verification
The bench drives all 16 low-threshold patterns and all 15 non-zero high-threshold patterns across the channels. This separates signalling-only behaviour from held shutdown, and shows that a held fault on one channel does not reach another. Held patterns are cleared in turn by power-down and by stopping PWM drive. The PWM acknowledge is probed at its exact edge and with a run one cycle short. A high-threshold flag held through a long idle run shows that set wins over clear. Each global flag is applied on its own, which separates disabling all outputs from touching the error flags or the warning output.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned OCP_SYNC_STAGES = 2;

  typedef struct packed {
    logic lo;
    logic hi;
    logic pwm;
  } ocp_chan_in_t;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ocp_chan.sv
module ocp_chan
  import ocp_pkg::*;
#(
  parameter int unsigned ACK_CYCLES = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ocp_chan_in_t in_i,
  input  logic         pd_i,
  input  logic         off_i,
  output logic         err_no,
  output logic         en_o,
  output logic         lat_o,
  output logic         ack_o
);
  localparam int unsigned CW = $clog2(ACK_CYCLES + 1);
  localparam logic [CW-1:0] ACK_VAL = CW'(ACK_CYCLES);

  logic [CW-1:0] idle_q;
  logic          ack;
  logic          lat_q, lat_d;
  logic          err_nq, en_q;

  assign ack = (idle_q == ACK_VAL);

  // saturating count of consecutive cycles with PWM drive low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idle_q <= '0;
    else if (in_i.pwm) idle_q <= '0;
    else if (!ack)    idle_q <= idle_q + 1'b1;
  end

  // power-down wins; otherwise set wins over clear
  always_comb begin
    if (pd_i) lat_d = 1'b0;
    else      lat_d = in_i.hi | (lat_q & ~ack);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= 1'b0;
      err_nq <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      err_nq <= ~(in_i.lo | lat_d);
      en_q   <= ~(lat_d | off_i);
    end
  end

  assign err_no = err_nq;
  assign en_o   = en_q;
  assign lat_o  = lat_q;
  assign ack_o  = ack;
endmodule

// File: rtl/ocp_fault_supervisor.sv
module ocp_fault_supervisor
  import ocp_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned ACK_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES = OCP_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_dn_ni,
  input  logic [NUM_CH-1:0] oc_lo_i,
  input  logic [NUM_CH-1:0] oc_hi_i,
  input  logic [NUM_CH-1:0] pwm_act_i,
  input  logic              temp_warn_i,
  input  logic              temp_shut_i,
  input  logic              uv_i,
  output logic [NUM_CH-1:0] err_no,
  output logic [NUM_CH-1:0] out_en_o,
  output logic              temp_warn_no
);
  localparam int unsigned FW = 3*NUM_CH + 3;

  logic [FW-1:0]     flags_raw, flags_s;
  logic              pd_n_s;
  logic [NUM_CH-1:0] lo_s, hi_s, pwm_s, lat_q, ack;
  logic              uv_s, tshut_s, twarn_s;
  logic              pd_act, off_all;
  logic              warn_nq;

  assign flags_raw = {temp_warn_i, temp_shut_i, uv_i, pwm_act_i, oc_hi_i, oc_lo_i};

  ocp_sync #(.W(FW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(flags_raw), .q_o(flags_s)
  );

  // power-down resets to the asserted level
  ocp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_dn_ni), .q_o(pd_n_s)
  );

  assign lo_s    = flags_s[NUM_CH-1:0];
  assign hi_s    = flags_s[2*NUM_CH-1:NUM_CH];
  assign pwm_s   = flags_s[3*NUM_CH-1:2*NUM_CH];
  assign uv_s    = flags_s[3*NUM_CH];
  assign tshut_s = flags_s[3*NUM_CH+1];
  assign twarn_s = flags_s[3*NUM_CH+2];

  assign pd_act  = ~pd_n_s;
  assign off_all = pd_act | tshut_s | uv_s;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ocp_chan_in_t cin;
    assign cin.lo  = lo_s[c];
    assign cin.hi  = hi_s[c];
    assign cin.pwm = pwm_s[c];

    ocp_chan #(.ACK_CYCLES(ACK_CYCLES)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (cin),
      .pd_i  (pd_act),
      .off_i (off_all),
      .err_no(err_no[c]),
      .en_o  (out_en_o[c]),
      .lat_o (lat_q[c]),
      .ack_o (ack[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_nq <= 1'b1;
    else         warn_nq <= ~twarn_s;
  end

  assign temp_warn_no = warn_nq;
endmodule

// File: rtl/ocp_fault_supervisor_chk.sv
module ocp_fault_supervisor_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] hi_s,
  input logic [NUM_CH-1:0] lat_q,
  input logic [NUM_CH-1:0] ack,
  input logic              pd_act,
  input logic              off_all,
  input logic [NUM_CH-1:0] err_no,
  input logic [NUM_CH-1:0] out_en_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_HI_SETS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_s[c] && !pd_act) |=> lat_q[c]); // R3
    AST_HOLD_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_q[c] |-> (!out_en_o[c] && !err_no[c])); // R3
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_q[c] && !ack[c] && !pd_act) |=> lat_q[c]); // R4
    AST_SET_OVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_q[c] && ack[c] && hi_s[c] && !pd_act) |=> lat_q[c]); // R5
  end

  AST_PD_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_act |=> (lat_q == '0)); // R6
  AST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_all |=> (out_en_o == '0)); // R8
endmodule

bind ocp_fault_supervisor ocp_fault_supervisor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hi_s    (hi_s),
  .lat_q   (lat_q),
  .ack     (ack),
  .pd_act  (pd_act),
  .off_all (off_all),
  .err_no  (err_no),
  .out_en_o(out_en_o)
);

// File: tb/tb_ocp_fault_supervisor.sv
module tb_ocp_fault_supervisor;
  localparam int NCH = 4;
  localparam int ACK = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           pwr_dn_ni = 1'b1;
  logic [NCH-1:0] oc_lo_i = '0, oc_hi_i = '0, pwm_act_i = '1;
  logic           temp_warn_i = 1'b0, temp_shut_i = 1'b0, uv_i = 1'b0;
  logic [NCH-1:0] err_no, out_en_o;
  logic           temp_warn_no;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  ocp_fault_supervisor #(.NUM_CH(NCH), .ACK_CYCLES(ACK)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_dn_ni(pwr_dn_ni),
    .oc_lo_i(oc_lo_i), .oc_hi_i(oc_hi_i), .pwm_act_i(pwm_act_i),
    .temp_warn_i(temp_warn_i), .temp_shut_i(temp_shut_i), .uv_i(uv_i),
    .err_no(err_no), .out_en_o(out_en_o), .temp_warn_no(temp_warn_no)
  );

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R10 err_no", err_no, '1);
    chk("R10 out_en_o", out_en_o, '0);
    chk("R10 temp_warn_no", {3'b0, temp_warn_no}, 4'b0001);
    rst_ni = 1'b1;
    wait_n(4);
    chk("R6 enable after power-up", out_en_o, '1);

    // R2: every low-threshold pattern signals only
    for (int p = 0; p < 16; p++) begin
      oc_lo_i = 4'(p);
      wait_n(3);
      chk("R2 err_no", err_no, ~4'(p));
      chk("R2 out_en_o", out_en_o, '1);
    end
    oc_lo_i = '0;
    wait_n(3);
    chk("R2 release", err_no, '1);

    // R3/R1: every high pattern holds; alternate clear by R6 and R4
    for (int p = 1; p < 16; p++) begin
      oc_hi_i = 4'(p);
      wait_n(3);
      chk("R3 err_no", err_no, ~4'(p));
      chk("R3 out_en_o", out_en_o, ~4'(p));
      oc_hi_i = '0;
      wait_n(4);
      chk("R3 sticky err_no", err_no, ~4'(p));
      chk("R1 sticky out_en_o", out_en_o, ~4'(p));
      if (p % 2 == 0) begin
        pwr_dn_ni = 1'b0;
        wait_n(3);
        chk("R6 off during power-down", out_en_o, '0);
        pwr_dn_ni = 1'b1;
        wait_n(4);
      end else begin
        pwm_act_i = ~4'(p);
        wait_n(ACK + 3);
        pwm_act_i = '1;
        wait_n(3);
      end
      chk("R4/R6 cleared err_no", err_no, '1);
      chk("R4/R6 cleared out_en_o", out_en_o, '1);
    end

    // R4 exact boundary and short run
    oc_hi_i = 4'b0011;
    wait_n(3);
    oc_hi_i = '0;
    wait_n(3);
    pwm_act_i = 4'b1110;
    wait_n(ACK + 2);
    chk("R4 not yet cleared", out_en_o, 4'b1100);
    wait_n(1);
    chk("R4 cleared at edge", out_en_o, 4'b1101);
    chk("R1 other ch err_no", err_no, 4'b1101);
    pwm_act_i = 4'b1101;
    wait_n(ACK - 1);
    pwm_act_i = '1;
    wait_n(8);
    chk("R4 short run keeps hold", out_en_o, 4'b1101);
    pwm_act_i = 4'b1101;
    wait_n(ACK + 3);
    pwm_act_i = '1;
    wait_n(3);
    chk("R4 ch1 cleared", out_en_o, '1);

    // R5 set over clear
    oc_hi_i = 4'b1000;
    pwm_act_i = 4'b0111;
    wait_n(ACK + 8);
    chk("R5 held while flag present", out_en_o, 4'b0111);
    oc_hi_i = '0;
    wait_n(4);
    chk("R5 clears after flag drops", out_en_o, '1);
    pwm_act_i = '1;
    wait_n(3);

    // R7
    temp_warn_i = 1'b1;
    wait_n(3);
    chk("R7 warn low", {3'b0, temp_warn_no}, 4'b0000);
    chk("R7 enables kept", out_en_o, '1);
    chk("R7 err kept", err_no, '1);
    temp_warn_i = 1'b0;
    wait_n(3);
    chk("R7 warn released", {3'b0, temp_warn_no}, 4'b0001);

    // R8
    oc_lo_i = 4'b0100;
    temp_shut_i = 1'b1;
    wait_n(3);
    chk("R8 all off", out_en_o, '0);
    chk("R8 err unaffected", err_no, 4'b1011);
    temp_shut_i = 1'b0;
    oc_lo_i = '0;
    wait_n(3);
    chk("R8 enables back", out_en_o, '1);

    // R9
    uv_i = 1'b1;
    wait_n(3);
    chk("R9 all off", out_en_o, '0);
    uv_i = 1'b0;
    wait_n(3);
    chk("R9 enables back", out_en_o, '1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule